// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit per step and delivers a product twice the operand width. A single double-width accumulator carries the multiplier operand in its lower half. Partial sums build up in its upper half. A conditional adder adds the held multiplicand into the upper half only when the accumulator's least significant bit is set. Otherwise it passes the upper half through unchanged.

A small controller issues three mutually exclusive strobes: load, add and shift. It runs them on a fixed schedule: one load cycle, then an add followed by a shift for each operand bit. It then settles in a terminal state and raises the done flag. For 32-bit operands the whole run takes exactly 65 clock cycles. Only a reset ends the terminal state, and the next multiplication starts from that reset. The carry out of each add is held and enters the top bit on the following shift, so the product is exact over the full unsigned range.

Top module: `shift_add_mul`

## Requirements
- R1: On the first rising edge after reset is released, the lower W bits of the product take `mplier_i`, the upper W bits clear to zero, and `mcand_i` is captured.
- R2: Changes on `mcand_i` and `mplier_i` after that load edge have no effect on any later product value or on the final result.
- R3: On each add step the upper half becomes upper half plus the held multiplicand when product bit 0 is 1. It stays unchanged when product bit 0 is 0, and the carry out of the addition is kept.
- R4: On each shift step the whole product shifts right by one bit, and the carry kept from the preceding add enters the top bit (bit 2W-1). So after i add/shift pairs the product equals (mcand * (mplier mod 2^i)) * 2^(W-i) + (mplier >> i).
- R5: `done_o` is 0 for the first 2W edges after reset release, and it is 1 from edge 2W+1 (edge 65 when W = 32).
- R6: Once `done_o` is 1 it stays 1, and the product does not change until the next reset.
- R7: When done, `product_o` equals the exact unsigned product mcand * mplier, including all-ones operands.
- R8: While `rst_ni` is low, `product_o` is zero and `done_o` is 0. Releasing reset starts a new multiplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; also starts each new multiplication |
| mcand_i | input | W | Multiplicand operand, sampled on the load edge |
| mplier_i | input | W | Multiplier operand, sampled on the load edge |
| product_o | output | 2W | Product accumulator; final result valid while done_o is 1 |
| done_o | output | 1 | High only in the terminal state |

## Verification
The bench builds two instances side by side, one at the default W = 32 and one at W = 4. Both are held against a behavioural model that predicts the accumulator after every shift and the exact cycle where done rises. The narrow instance brings the full 4-bit operand space within reach, so every carry and bit pattern the adder can see is covered. The 32-bit instance exercises zero, one, all-ones, alternating and pseudo-random operands, along with operand changes after the load edge.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_END   = 2'd3
  } mul_state_e;

  typedef struct packed {
    logic load;
    logic add;
    logic shift;
  } mul_ctl_t;

endpackage

// File: rtl/sam_mcand_reg.sv
module sam_mcand_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;

  p_mcand_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_q))
    else $error("multiplicand changed outside load");

endmodule

// File: rtl/sam_cond_adder.sv
module sam_cond_adder #(
  parameter int W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] mcand_i,
  output logic [W:0]   sum_o
);

  always_comb begin
    if (en_i) sum_o = {1'b0, hi_i} + {1'b0, mcand_i};
    else      sum_o = {1'b0, hi_i};
  end

  always_comb begin
    if (!en_i) a_pass_r3: assert (sum_o[W-1:0] == hi_i && !sum_o[W])
      else $error("adder did not pass high half through");
  end

endmodule

// File: rtl/sam_prod_reg.sv
module sam_prod_reg
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mul_ctl_t      ctl_i,
  input  logic [W-1:0]  mplier_i,
  input  logic [W:0]    sum_i,
  output logic [W-1:0]  hi_o,
  output logic          lsb_o,
  output logic [PW-1:0] prod_o
);

  logic [PW-1:0] prod_q;
  logic          carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      carry_q <= 1'b0;
    end else if (ctl_i.load) begin
      prod_q  <= {{W{1'b0}}, mplier_i};
      carry_q <= 1'b0;
    end else if (ctl_i.add) begin
      prod_q[PW-1:W] <= sum_i[W-1:0];
      carry_q        <= sum_i[W];
    end else if (ctl_i.shift) begin
      prod_q  <= {carry_q, prod_q[PW-1:1]};
      carry_q <= 1'b0;
    end
  end

  assign hi_o   = prod_q[PW-1:W];
  assign lsb_o  = prod_q[0];
  assign prod_o = prod_q;

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.load |=> (prod_q == {{W{1'b0}}, $past(mplier_i)}))
    else $error("load did not seed product");

  p_add_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.add && !prod_q[0]) |=> $stable(prod_q))
    else $error("add with clear lsb altered product");

  p_add_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.add |=> $stable(prod_q[W-1:0]))
    else $error("add touched low half");

  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.shift |=> (prod_q[PW-2:0] == $past(prod_q[PW-1:1])))
    else $error("shift mismatch");

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_i.load || ctl_i.add || ctl_i.shift) |=> $stable(prod_q))
    else $error("product moved while idle");

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32,
  localparam int LAST = 2 * W + 1,
  localparam int CW = $clog2(LAST + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output mul_ctl_t ctl_o,
  output logic     done_o
);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD:  state_d = ST_ADD;
      ST_ADD:   state_d = ST_SHIFT;
      ST_SHIFT: state_d = (cnt_q == CW'(LAST - 1)) ? ST_END : ST_ADD;
      ST_END:   state_d = ST_END;
      default:  state_d = ST_END;
    endcase
  end

  // output decode
  always_comb begin
    ctl_o       = '0;
    ctl_o.load  = (state_q == ST_LOAD);
    ctl_o.add   = (state_q == ST_ADD);
    ctl_o.shift = (state_q == ST_SHIFT);
  end

  assign done_o = (state_q == ST_END);

  // state register and step counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_END) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_strobe_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_o.load, ctl_o.add, ctl_o.shift}))
    else $error("strobes overlap");

  p_add_then_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADD) |=> (state_q == ST_SHIFT))
    else $error("add not followed by shift");

  p_done_at_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cnt_q == CW'(LAST)))
    else $error("done rose at wrong count");

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o)
    else $error("left terminal state");

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);

  mul_ctl_t     ctl;
  logic [W-1:0] mcand_q;
  logic [W-1:0] hi;
  logic         lsb;
  logic [W:0]   sum;

  sam_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_o  (ctl),
    .done_o (done_o)
  );

  sam_mcand_reg #(.W(W)) u_mcand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctl.load),
    .d_i    (mcand_i),
    .q_o    (mcand_q)
  );

  sam_cond_adder #(.W(W)) u_add (
    .en_i    (lsb),
    .hi_i    (hi),
    .mcand_i (mcand_q),
    .sum_o   (sum)
  );

  sam_prod_reg #(.W(W)) u_prod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .mplier_i (mplier_i),
    .sum_i    (sum),
    .hi_o     (hi),
    .lsb_o    (lsb),
    .prod_o   (product_o)
  );

  p_done_product_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(product_o))
    else $error("product moved after done");

endmodule

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] a32, b32;
  logic [3:0]  a4, b4;
  logic [63:0] p32;
  logic [7:0]  p4;
  logic        d32, d4;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  shift_add_mul #(.W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mcand_i(a32), .mplier_i(b32),
    .product_o(p32), .done_o(d32));

  shift_add_mul #(.W(4)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .mcand_i(a4), .mplier_i(b4),
    .product_o(p4), .done_o(d4));

  // expected product after n edges from reset release
  function automatic logic [127:0] model(int n, int w, logic [63:0] a, logic [63:0] b);
    logic [127:0] mask;
    int i;
    if (n <= 1) return {64'd0, b};
    i = (n - 1) / 2;
    if (i > w) i = w;
    mask = (128'd1 << i) - 128'd1;
    return ((128'(a) * (128'(b) & mask)) << (w - i)) | (128'(b) >> i);
  endfunction

  task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check(int n, int w, logic [63:0] a, logic [63:0] b,
                       logic [63:0] prod, logic done);
    logic [127:0] e;
    e = model(n, w, a, b);
    cmp((n >= 2*w+1) ? "R5 done high" : "R5 done low", 128'(done), 128'(n >= 2*w+1));
    if (n == 1)                        cmp("R1 load", 128'(prod), e);
    else if (n > 2*w+1)                cmp("R6 hold", 128'(prod), 128'(a) * 128'(b));
    else if (n == 2*w+1)               cmp("R7 final", 128'(prod), 128'(a) * 128'(b));
    else if (n % 2 == 1)               cmp("R3 R4 step", 128'(prod), e);
  endtask

  // one multiplication on both instances; optionally scramble inputs after load (R2)
  task automatic run_op(logic [31:0] ia, logic [31:0] ib, logic [3:0] na, logic [3:0] nb,
                        bit scramble, int len);
    @(negedge clk);
    rst_n = 1'b0;
    a32 = ia; b32 = ib; a4 = na; b4 = nb;
    @(negedge clk);
    cmp("R8 reset done", 128'(d32 | d4), 128'd0);
    cmp("R8 reset prod", 128'(p32 | 64'(p4)), 128'd0);
    rst_n = 1'b1;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      check(n, 32, 64'(ia), 64'(ib), p32, d32);
      check(n, 4,  64'(na), 64'(nb), 64'(p4), d4);
      if (scramble) begin
        a32 = ~a32 ^ 32'(n * 7919); b32 = b32 + 32'h1357_9bdf;
        a4  = a4 + 4'd3;            b4  = ~b4;
      end
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    a32 = '0; b32 = '0; a4 = '0; b4 = '0;
    lfsr = 32'hace1_2467;
    repeat (3) @(negedge clk);
    // corner operands at 32 bits, held past done (R6)
    run_op(32'd5, 32'd34, 4'd5, 4'd3, 1'b0, 70);
    run_op(32'd0, 32'hffff_ffff, 4'd0, 4'hf, 1'b0, 68);
    run_op(32'hffff_ffff, 32'd0, 4'hf, 4'd0, 1'b0, 68);
    run_op(32'd1, 32'hdead_beef, 4'd1, 4'd9, 1'b0, 68);
    run_op(32'hffff_ffff, 32'hffff_ffff, 4'hf, 4'hf, 1'b0, 70);
    run_op(32'haaaa_aaaa, 32'h5555_5555, 4'ha, 4'h5, 1'b1, 70);
    run_op(32'h8000_0000, 32'h8000_0001, 4'h8, 4'h9, 1'b1, 68);
    // exhaustive narrow instance, random wide operands
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        run_op(lfsr, {lfsr[15:0], lfsr[31:16]} ^ 32'h0f0f_3c3c, 4'(i), 4'(j),
               ((i + j) % 3) == 0, 66);
      end
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule